// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps, for a single thread, the ordered log of register renames made at the rename stage. Each destination register that is renamed adds one record at the newest end. A record holds the instruction's sequence number, the architectural register, the physical register just allocated, and the physical register that the architectural register mapped to before. The same log serves both misprediction recovery and register reclamation. A squash walks it from the newest end and rolls the mapping back. A commit walks it from the oldest end and hands the superseded physical registers back for reuse.

The map table, the free list and the ready scoreboard sit outside the block. The block drives write strobes toward them: a map restore port, a free-list return port, a ready-set port and a ready-clear port. A walk retires one record per cycle and raises `busy` for as long as it runs. Sequence numbers are compared as plain unsigned values, and the caller presents them in increasing order of insertion.

Top module: `rename_history_buf`

## Requirements
- R1: After reset the log is empty. `busy` is 0, `ins_ready` is 1 when no request is present, and no write strobe is active.
- R2: `ins_ready` is 1 only when the block is idle, the log is not full, and none of `sq_valid`, `flush` or `cm_valid` is high in that cycle. An insert is accepted when `ins_valid` and `ins_ready` are both high. In that same cycle `rdy_clr_we` pulses with `rdy_clr_phys` equal to `ins_new_phys`.
- R3: The log holds DEPTH records. When it is full, `ins_ready` is 0 and further inserts are refused.
- R4: A squash request presented while idle starts a walk when the newest record's sequence number is greater than `sq_seq`. From the next cycle on, `busy` is 1. Each busy cycle removes the newest record and drives two writes: `map_we` with that record's architectural register and previous physical register, and `free_we` with its new physical register. The walk ends after the last record whose sequence number is greater than `sq_seq`.
- R5: When a record removed by a squash or flush has a new physical register index at or above INT_PHYS+FP_PHYS, `rdy_set_we` pulses with that index in the same cycle.
- R6: A commit request presented while idle starts a walk when the oldest record's sequence number is at most `cm_seq`. Each busy cycle removes the oldest record and drives `free_we` with its previous physical register, with no map write. The walk ends after the last record whose sequence number is at most `cm_seq`.
- R7: Some requests are ignored entirely: a commit whose number is below the oldest record, a squash that has no younger record, and any request on an empty log. An ignored request leaves `busy` at 0 and drives no write strobe.
- R8: A flush removes every record, newest first, with the same outputs per record as a squash.
- R9: When several requests arrive in the same idle cycle, a flush takes precedence over a squash. A cycle that carries a squash or a flush discards any commit request, even when the squash turns out to be a no-op.
- R10: Requests of any kind presented while `busy` is 1 are ignored. A running walk is neither extended nor preempted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Insert a rename record |
| ins_ready | output | 1 | Insert can be accepted this cycle |
| ins_seq | input | SEQ_W | Sequence number of the record |
| ins_arch | input | ARCH_W | Architectural register |
| ins_new_phys | input | PHYS_W | Newly allocated physical register |
| ins_prev_phys | input | PHYS_W | Previous physical register |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Records younger than this are undone |
| flush | input | 1 | Undo every record |
| cm_valid | input | 1 | Commit request |
| cm_seq | input | SEQ_W | Records up to this number are retired |
| busy | output | 1 | A walk is in progress |
| map_we | output | 1 | Map restore strobe |
| map_arch | output | ARCH_W | Architectural register to restore |
| map_phys | output | PHYS_W | Physical register written back into the map |
| free_we | output | 1 | Free-list return strobe |
| free_phys | output | PHYS_W | Physical register returned |
| rdy_set_we | output | 1 | Ready-bit set strobe |
| rdy_set_phys | output | PHYS_W | Register whose ready bit is set |
| rdy_clr_we | output | 1 | Ready-bit clear strobe |
| rdy_clr_phys | output | PHYS_W | Register whose ready bit is cleared |

## Verification
The directed patterns test several things. A commit below the oldest record checks that the block ignores it rather than starting a walk. A partial commit followed by a partial squash shows that each end stops at the right record and that the right field goes out on each port. Records with new registers above the miscellaneous threshold tell a squash that sets ready bits apart from one that leaves them alone. Combined requests separate flush-over-squash priority from squash-over-commit priority. Requests injected during a walk show whether it can be preempted. Filling to capacity and flushing covers the full boundary. A long random mix of inserts, squashes, commits and flushes with increasing sequence numbers compares every output each cycle against a queue model, which catches off-by-one stop conditions and pointer wrap.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
    typedef enum logic [1:0] {
        WALK_IDLE   = 2'd0,
        WALK_SQUASH = 2'd1,
        WALK_FLUSH  = 2'd2,
        WALK_COMMIT = 2'd3
    } walk_e;
endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
    parameter int DEPTH = 8,
    parameter int REC_W = 32,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [REC_W-1:0] push_rec,
    input  logic             pop_new,
    input  logic             pop_old,
    output logic [CW-1:0]    count,
    output logic [REC_W-1:0] newest,
    output logic [REC_W-1:0] newest2,
    output logic [REC_W-1:0] oldest,
    output logic [REC_W-1:0] oldest2
);
    typedef struct packed {
        logic [DEPTH-1:0][REC_W-1:0] mem;
        logic [PW-1:0]               head;
        logic [PW-1:0]               tail;
        logic [CW-1:0]               cnt;
    } st_t;

    st_t s_d, s_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.head] = push_rec;
            s_d.head          = ptr_inc(s_q.head);
        end
        if (pop_new) s_d.head = ptr_dec(s_q.head);
        if (pop_old) s_d.tail = ptr_inc(s_q.tail);
        s_d.cnt = s_q.cnt + CW'(push) - CW'(pop_new) - CW'(pop_old);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count   = s_q.cnt;
    assign newest  = s_q.mem[ptr_dec(s_q.head)];
    assign newest2 = s_q.mem[ptr_dec(ptr_dec(s_q.head))];
    assign oldest  = s_q.mem[s_q.tail];
    assign oldest2 = s_q.mem[ptr_inc(s_q.tail)];

    // R3: never written past capacity
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (s_q.cnt < CW'(DEPTH)));
    // R4: a walk never removes from an empty log
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_new || pop_old) |-> (s_q.cnt != '0));
    // R2: inserts never coincide with a walk step
    p_push_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !(pop_new || pop_old));
endmodule

// File: rtl/rhb_walk.sv
module rhb_walk
    import rhb_pkg::*;
#(
    parameter int SEQ_W = 12,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sq_req,
    input  logic             fl_req,
    input  logic             cm_req,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic [SEQ_W-1:0] cm_seq,
    input  logic [CW-1:0]    count,
    input  logic [SEQ_W-1:0] new_seq,
    input  logic [SEQ_W-1:0] new2_seq,
    input  logic [SEQ_W-1:0] old_seq,
    input  logic [SEQ_W-1:0] old2_seq,
    output logic             pop_new,
    output logic             pop_old,
    output logic             busy
);
    typedef struct packed {
        walk_e            mode;
        logic [SEQ_W-1:0] tgt;
    } st_t;

    st_t  s_d, s_q;
    logic last_rec;
    logic empty;

    always_comb begin
        s_d      = s_q;
        last_rec = (count == CW'(1));
        empty    = (count == '0);
        case (s_q.mode)
            WALK_IDLE: begin
                if (fl_req) begin
                    if (!empty) s_d.mode = WALK_FLUSH;
                end else if (sq_req) begin
                    if (!empty && (new_seq > sq_seq)) begin
                        s_d.mode = WALK_SQUASH;
                        s_d.tgt  = sq_seq;
                    end
                end else if (cm_req) begin
                    if (!empty && (old_seq <= cm_seq)) begin
                        s_d.mode = WALK_COMMIT;
                        s_d.tgt  = cm_seq;
                    end
                end
            end
            WALK_SQUASH: if (last_rec || (new2_seq <= s_q.tgt)) s_d.mode = WALK_IDLE;
            WALK_FLUSH:  if (last_rec) s_d.mode = WALK_IDLE;
            WALK_COMMIT: if (last_rec || (old2_seq > s_q.tgt)) s_d.mode = WALK_IDLE;
            default:     s_d.mode = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pop_new = (s_q.mode == WALK_SQUASH) || (s_q.mode == WALK_FLUSH);
    assign pop_old = (s_q.mode == WALK_COMMIT);
    assign busy    = (s_q.mode != WALK_IDLE);

    // R4: a squash step only ever removes a record younger than the target
    p_squash_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == WALK_SQUASH) |-> (new_seq > s_q.tgt));
    // R6: a commit step only ever retires a record at or below the target
    p_commit_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == WALK_COMMIT) |-> (old_seq <= s_q.tgt));
    // R10: a commit walk cannot be preempted by a later squash or flush
    p_no_preempt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == WALK_COMMIT) |=> (s_q.mode == WALK_COMMIT || s_q.mode == WALK_IDLE));
    // R9: a squash or flush in an idle cycle never leads to a commit walk
    p_squash_over_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == WALK_IDLE && (sq_req || fl_req)) |=> (s_q.mode != WALK_COMMIT));
endmodule

// File: rtl/rename_history_buf.sv
module rename_history_buf #(
    parameter int DEPTH   = 8,
    parameter int SEQ_W   = 12,
    parameter int ARCH_W  = 5,
    parameter int PHYS_W  = 7,
    parameter int INT_PHYS = 48,
    parameter int FP_PHYS  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [SEQ_W-1:0]  ins_seq,
    input  logic [ARCH_W-1:0] ins_arch,
    input  logic [PHYS_W-1:0] ins_new_phys,
    input  logic [PHYS_W-1:0] ins_prev_phys,
    input  logic              sq_valid,
    input  logic [SEQ_W-1:0]  sq_seq,
    input  logic              flush,
    input  logic              cm_valid,
    input  logic [SEQ_W-1:0]  cm_seq,
    output logic              busy,
    output logic              map_we,
    output logic [ARCH_W-1:0] map_arch,
    output logic [PHYS_W-1:0] map_phys,
    output logic              free_we,
    output logic [PHYS_W-1:0] free_phys,
    output logic              rdy_set_we,
    output logic [PHYS_W-1:0] rdy_set_phys,
    output logic              rdy_clr_we,
    output logic [PHYS_W-1:0] rdy_clr_phys
);
    localparam int MISC_BASE = INT_PHYS + FP_PHYS;
    localparam int REC_W     = SEQ_W + ARCH_W + 2 * PHYS_W;
    localparam int CW        = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [ARCH_W-1:0] arch;
        logic [PHYS_W-1:0] np;
        logic [PHYS_W-1:0] pp;
    } rec_t;

    rec_t          in_rec, r_new, r_new2, r_old, r_old2;
    logic [CW-1:0] count;
    logic          pop_new, pop_old, push;

    assign in_rec = '{seq: ins_seq, arch: ins_arch, np: ins_new_phys, pp: ins_prev_phys};

    assign ins_ready = !busy && (count != CW'(DEPTH)) && !sq_valid && !flush && !cm_valid;
    assign push      = ins_valid && ins_ready;

    rhb_store #(.DEPTH(DEPTH), .REC_W(REC_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_rec (in_rec),
        .pop_new  (pop_new),
        .pop_old  (pop_old),
        .count    (count),
        .newest   (r_new),
        .newest2  (r_new2),
        .oldest   (r_old),
        .oldest2  (r_old2)
    );

    rhb_walk #(.SEQ_W(SEQ_W), .CW(CW)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sq_req   (sq_valid),
        .fl_req   (flush),
        .cm_req   (cm_valid),
        .sq_seq   (sq_seq),
        .cm_seq   (cm_seq),
        .count    (count),
        .new_seq  (r_new.seq),
        .new2_seq (r_new2.seq),
        .old_seq  (r_old.seq),
        .old2_seq (r_old2.seq),
        .pop_new  (pop_new),
        .pop_old  (pop_old),
        .busy     (busy)
    );

    assign map_we       = pop_new;
    assign map_arch     = r_new.arch;
    assign map_phys     = r_new.pp;
    assign free_we      = pop_new || pop_old;
    assign free_phys    = pop_new ? r_new.np : r_old.pp;
    assign rdy_set_we   = pop_new && (r_new.np >= PHYS_W'(MISC_BASE));
    assign rdy_set_phys = r_new.np;
    assign rdy_clr_we   = push;
    assign rdy_clr_phys = ins_new_phys;

    // R2: no insert is ever offered while a walk runs
    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ins_ready);
    // R5: ready bits are only set alongside a rollback of a miscellaneous register
    p_rdy_set_undo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_set_we |-> (map_we && free_we && (rdy_set_phys == free_phys)));
    // R6: commit returns registers without touching the map
    p_commit_no_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (free_we && !map_we) |-> !rdy_set_we);
endmodule

// File: tb/rename_history_buf_tb.sv
module rename_history_buf_tb;
    localparam int DEPTH  = 8;
    localparam int SEQ_W  = 12;
    localparam int ARCH_W = 5;
    localparam int PHYS_W = 7;
    localparam int MISC   = 96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 0, sq_valid = 0, flush = 0, cm_valid = 0;
    logic [SEQ_W-1:0]  ins_seq = '0, sq_seq = '0, cm_seq = '0;
    logic [ARCH_W-1:0] ins_arch = '0;
    logic [PHYS_W-1:0] ins_new_phys = '0, ins_prev_phys = '0;
    logic ins_ready, busy, map_we, free_we, rdy_set_we, rdy_clr_we;
    logic [ARCH_W-1:0] map_arch;
    logic [PHYS_W-1:0] map_phys, free_phys, rdy_set_phys, rdy_clr_phys;

    always #4 clk = ~clk;

    rename_history_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W),
                         .INT_PHYS(48), .FP_PHYS(48)) u_dut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_seq(ins_seq), .ins_arch(ins_arch), .ins_new_phys(ins_new_phys),
        .ins_prev_phys(ins_prev_phys), .sq_valid(sq_valid), .sq_seq(sq_seq),
        .flush(flush), .cm_valid(cm_valid), .cm_seq(cm_seq), .busy(busy),
        .map_we(map_we), .map_arch(map_arch), .map_phys(map_phys),
        .free_we(free_we), .free_phys(free_phys), .rdy_set_we(rdy_set_we),
        .rdy_set_phys(rdy_set_phys), .rdy_clr_we(rdy_clr_we), .rdy_clr_phys(rdy_clr_phys));

    typedef struct { int seq; int arch; int np; int pp; } rec_t;
    rec_t  q[$];
    int    m_mode = 0;   // 0 idle, 1 squash, 2 flush, 3 commit
    int    m_tgt  = 0;
    int    vectors = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clr();
        ins_valid = 0; sq_valid = 0; flush = 0; cm_valid = 0;
    endtask

    // compare all outputs against the queue model, then advance it one clock
    task automatic step();
        bit e_ready, walk_new;
        #1;
        e_ready  = (m_mode == 0) && (q.size() < DEPTH) && !sq_valid && !flush && !cm_valid;
        walk_new = (m_mode == 1 || m_mode == 2);
        chk(cur_req, "busy", int'(busy), int'(m_mode != 0));
        chk("R2", "ins_ready", int'(ins_ready), int'(e_ready));
        chk("R2", "rdy_clr_we", int'(rdy_clr_we), int'(ins_valid && e_ready));
        if (ins_valid && e_ready) chk("R2", "rdy_clr_phys", int'(rdy_clr_phys), int'(ins_new_phys));
        chk(cur_req, "map_we", int'(map_we), int'(walk_new));
        chk(cur_req, "free_we", int'(free_we), int'(m_mode != 0));
        if (walk_new) begin
            chk(cur_req, "map_arch", int'(map_arch), q[$].arch);
            chk(cur_req, "map_phys", int'(map_phys), q[$].pp);
            chk(cur_req, "free_phys", int'(free_phys), q[$].np);
            chk("R5", "rdy_set_we", int'(rdy_set_we), int'(q[$].np >= MISC));
            if (q[$].np >= MISC) chk("R5", "rdy_set_phys", int'(rdy_set_phys), q[$].np);
        end else begin
            chk("R5", "rdy_set_we", int'(rdy_set_we), 0);
            if (m_mode == 3) chk(cur_req, "free_phys", int'(free_phys), q[0].pp);
        end
        if (walk_new) begin
            void'(q.pop_back());
            if (q.size() == 0 || (m_mode == 1 && q[$].seq <= m_tgt)) m_mode = 0;
        end else if (m_mode == 3) begin
            void'(q.pop_front());
            if (q.size() == 0 || q[0].seq > m_tgt) m_mode = 0;
        end else begin
            if (flush) begin
                if (q.size() > 0) m_mode = 2;
            end else if (sq_valid) begin
                if (q.size() > 0 && q[$].seq > int'(sq_seq)) begin m_mode = 1; m_tgt = int'(sq_seq); end
            end else if (cm_valid) begin
                if (q.size() > 0 && q[0].seq <= int'(cm_seq)) begin m_mode = 3; m_tgt = int'(cm_seq); end
            end
            if (ins_valid && e_ready)
                q.push_back('{int'(ins_seq), int'(ins_arch), int'(ins_new_phys), int'(ins_prev_phys)});
        end
        @(negedge clk);
    endtask

    task automatic do_ins(input int s, input int a, input int np, input int pp);
        ins_valid = 1; ins_seq = SEQ_W'(s); ins_arch = ARCH_W'(a);
        ins_new_phys = PHYS_W'(np); ins_prev_phys = PHYS_W'(pp);
        step(); clr();
    endtask

    task automatic drain();
        for (int i = 0; i < 3 * DEPTH && m_mode != 0; i++) step();
    endtask

    task automatic busy_after(input string req, input int exp);
        #1 chk(req, "busy after request", int'(busy), exp);
    endtask

    int seq_ctr;
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        cur_req = "R1";
        chk("R1", "busy at reset", int'(busy), 0);
        chk("R1", "ins_ready at reset", int'(ins_ready), 1);
        chk("R1", "free_we at reset", int'(free_we), 0);
        step();

        cur_req = "R2";
        do_ins(10, 1, 40, 1);
        do_ins(11, 2, 100, 2);
        do_ins(12, 3, 41, 3);
        do_ins(13, 1, 101, 40);
        do_ins(14, 4, 42, 4);

        cur_req = "R7";   // commit older than oldest record is ignored
        cm_valid = 1; cm_seq = 5; step(); clr();
        busy_after("R7", 0);
        step();

        cur_req = "R6";   // retire 10 and 11 from the oldest end
        cm_valid = 1; cm_seq = 11; step(); clr();
        busy_after("R6", 1);
        drain();

        cur_req = "R4";   // undo 14 then 13 (13 frees a miscellaneous register, R5)
        sq_valid = 1; sq_seq = 12; step(); clr();
        busy_after("R4", 1);
        drain();
        busy_after("R4", 0);

        cur_req = "R10";  // requests during a walk are ignored
        do_ins(20, 5, 50, 5);
        do_ins(21, 6, 110, 6);
        do_ins(22, 7, 51, 7);
        sq_valid = 1; sq_seq = 20; step(); clr();
        flush = 1; step(); clr();
        cm_valid = 1; cm_seq = 30; step(); clr();
        drain();

        cur_req = "R9";   // flush wins over squash, squash discards commit
        do_ins(23, 8, 60, 8);
        do_ins(24, 9, 61, 9);
        sq_valid = 1; sq_seq = 40; cm_valid = 1; cm_seq = 40; step(); clr();
        busy_after("R9", 0);
        sq_valid = 1; sq_seq = 23; flush = 1; step(); clr();
        drain();
        busy_after("R9", 0);

        cur_req = "R3";   // fill to capacity, a ninth insert is refused
        for (int i = 0; i < DEPTH + 1; i++) do_ins(30 + i, i, 97 + i, 10 + i);
        #1 chk("R3", "ins_ready when full", int'(ins_ready), 0);

        cur_req = "R8";
        flush = 1; step(); clr();
        drain();

        cur_req = "R7";   // requests on an empty log
        cm_valid = 1; cm_seq = 100; step(); clr();
        busy_after("R7", 0);
        sq_valid = 1; sq_seq = 0; step(); clr();
        busy_after("R7", 0);
        flush = 1; step(); clr();
        busy_after("R8", 0);

        cur_req = "R4";   // random mix, all requirements under the model
        seq_ctr = 100;
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r <= 5) begin
                seq_ctr += $urandom_range(1, 2);
                ins_valid = 1; ins_seq = SEQ_W'(seq_ctr);
                ins_arch = ARCH_W'($urandom_range(0, 31));
                ins_new_phys = PHYS_W'($urandom_range(0, 127));
                ins_prev_phys = PHYS_W'($urandom_range(0, 127));
            end else if (r == 6) begin
                sq_valid = 1;
                sq_seq = SEQ_W'((q.size() > 0) ? $urandom_range(q[0].seq - 1, q[$].seq) : seq_ctr);
            end else if (r == 7) begin
                cm_valid = 1;
                cm_seq = SEQ_W'((q.size() > 0) ? $urandom_range(q[0].seq - 1, q[$].seq) : seq_ctr);
            end else if (r == 8 && $urandom_range(0, 3) == 0) begin
                flush = 1;
            end
            step(); clr();
        end
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule